// File: doc/BRIEF.md
# Decode Operand Forwarding and Load-Use Interlock

This block sits beside the decode stage of an in-order five-stage pipeline. It takes the two register numbers that decode wants to read, together with the values the register file returns for them. It replaces each value with a newer one whenever a load that has not yet written back targets the same register. The only possible sources of a newer value are load results. A load in the memory stage supplies the word it has just read from data memory. A load in the writeback stage supplies the word latched for the register-file write.

The same block also detects the one dependency that forwarding cannot cover. This is a load still in execute whose destination is one of the decode sources. When that happens, it holds the fetch register and the decode-entry register, and it injects a no-op into the execute-entry register. After one such cycle the load has moved to memory, where forwarding can reach it. The block is purely combinational. The register file, the data memory and the pipeline registers sit outside it.

Top module: `dec_fwd_interlock`

## Requirements
- R1: A decode source equal to the "none" register code (all ones, 4'hF at the default width) yields an operand of 0, whatever the other inputs are.
- R2: When a source is not "none" and equals the memory-stage destination, the operand is the memory-stage read value, even if the writeback-stage destination also matches.
- R3: When a source is not "none", does not match the memory-stage destination, and equals the writeback-stage destination, the operand is the writeback-stage value.
- R4: When a source is not "none" and matches neither destination, the operand is the register-file read value for that port.
- R5: Operand A and operand B are selected independently. Each uses only its own source and register-file value, so each may take a different path in the same cycle.
- R6: A destination of "none" in the memory, writeback or execute stage never matches a source, so it never forwards and never raises the load-use flag.
- R7: The load-use flag is 1 exactly when the execute-stage opcode is the load code (4'h5 at the default width), the execute destination is not "none", and that destination equals source A or source B.
- R8: A match on either source raises the flag, with no regard to whether that operand is consumed later.
- R9: The stall-fetch, stall-decode and bubble-execute outputs each equal the load-use flag. When there is no hazard, all three are 0, including when a non-load opcode in execute has a matching destination.
- R10: For two back-to-back dependent loads, the interlock asserts in the first decode cycle only. In the following cycle the load sits in memory with a no-op in execute, and the operand is forwarded from memory with no stall. At distance three the operand comes from writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | 4 | Decode source register A |
| src_b_i | input | 4 | Decode source register B |
| rf_a_i | input | 64 | Register-file read value for source A |
| rf_b_i | input | 64 | Register-file read value for source B |
| mem_dst_i | input | 4 | Load destination in memory stage |
| mem_val_i | input | 64 | Word just read from data memory |
| wb_dst_i | input | 4 | Load destination in writeback stage |
| wb_val_i | input | 64 | Latched writeback value |
| ex_op_i | input | 4 | Opcode in execute stage |
| ex_dst_i | input | 4 | Load destination in execute stage |
| opnd_a_o | output | 64 | Forwarded operand A |
| opnd_b_o | output | 64 | Forwarded operand B |
| load_use_o | output | 1 | Load-use hazard flag |
| stall_fetch_o | output | 1 | Hold fetch register |
| stall_dec_o | output | 1 | Hold decode-entry register |
| bubble_ex_o | output | 1 | Insert no-op into execute-entry register |

## Verification
The block holds no state, so any wrong selection is visible on the operand or control outputs in the same cycle as the input pattern that provokes it. A wrong priority shows when both later-stage destinations match a source and the memory value is not the one that appears. A missing "none" guard shows as a forwarded value or a false stall against an idle slot. The random stimulus draws register numbers from a small set that includes "none", so every overlap of source and destination occurs many times.

// File: rtl/dec_fwd_pkg.sv
package dec_fwd_pkg;
  localparam int unsigned REG_W_DEF  = 4;
  localparam int unsigned DATA_W_DEF = 64;
  localparam int unsigned OP_W_DEF   = 4;
  localparam int unsigned LOAD_OP_DEF = 5;

  typedef struct packed {
    logic stall_fetch;
    logic stall_dec;
    logic bubble_ex;
  } hz_ctrl_t;
endpackage

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux #(
  parameter int unsigned REG_W  = dec_fwd_pkg::REG_W_DEF,
  parameter int unsigned DATA_W = dec_fwd_pkg::DATA_W_DEF
) (
  input  logic [REG_W-1:0]  src_i,
  input  logic [DATA_W-1:0] rf_i,
  input  logic [REG_W-1:0]  mem_dst_i,
  input  logic [DATA_W-1:0] mem_val_i,
  input  logic [REG_W-1:0]  wb_dst_i,
  input  logic [DATA_W-1:0] wb_val_i,
  output logic [DATA_W-1:0] opnd_o
);
  localparam logic [REG_W-1:0] REG_NONE = '1;

  logic src_none, mem_hit, wb_hit;

  assign src_none = (src_i == REG_NONE);
  assign mem_hit  = (mem_dst_i != REG_NONE) && (src_i == mem_dst_i);
  assign wb_hit   = (wb_dst_i  != REG_NONE) && (src_i == wb_dst_i);

  // memory stage is younger, so it wins over writeback
  always_comb begin
    if (src_none)     opnd_o = '0;
    else if (mem_hit) opnd_o = mem_val_i;
    else if (wb_hit)  opnd_o = wb_val_i;
    else              opnd_o = rf_i;
  end

  always_comb begin
    if (src_none) a_r1_none_zero: assert (opnd_o == '0);
    if (!src_none && mem_hit) a_r2_mem_first: assert (opnd_o == mem_val_i);
    if (!src_none && !mem_hit && !wb_hit) a_r4_rf_path: assert (opnd_o == rf_i);
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int unsigned REG_W   = dec_fwd_pkg::REG_W_DEF,
  parameter int unsigned OP_W    = dec_fwd_pkg::OP_W_DEF,
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned LOAD_OP = dec_fwd_pkg::LOAD_OP_DEF
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] src_i,
  input  logic [OP_W-1:0]               ex_op_i,
  input  logic [REG_W-1:0]              ex_dst_i,
  output logic                          load_use_o,
  output dec_fwd_pkg::hz_ctrl_t         ctrl_o
);
  localparam logic [REG_W-1:0] REG_NONE = '1;
  localparam logic [OP_W-1:0]  OP_LOAD  = OP_W'(LOAD_OP);

  logic                ex_is_load;
  logic [NUM_SRC-1:0]  src_hit;

  assign ex_is_load = (ex_op_i == OP_LOAD) && (ex_dst_i != REG_NONE);

  // any source match counts, consumed or not
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_hit[g] = ex_is_load && (src_i[g] == ex_dst_i);
  end

  assign load_use_o         = |src_hit;
  assign ctrl_o.stall_fetch = load_use_o;
  assign ctrl_o.stall_dec   = load_use_o;
  assign ctrl_o.bubble_ex   = load_use_o;

  always_comb begin
    if (ex_dst_i == REG_NONE) a_r6_none_no_hazard: assert (!load_use_o);
    if (ex_op_i != OP_LOAD) a_r9_nonload_quiet: assert (ctrl_o == '0);
  end
endmodule

// File: rtl/dec_fwd_interlock.sv
module dec_fwd_interlock #(
  parameter int unsigned REG_W   = dec_fwd_pkg::REG_W_DEF,
  parameter int unsigned DATA_W  = dec_fwd_pkg::DATA_W_DEF,
  parameter int unsigned OP_W    = dec_fwd_pkg::OP_W_DEF,
  parameter int unsigned LOAD_OP = dec_fwd_pkg::LOAD_OP_DEF
) (
  input  logic [REG_W-1:0]  src_a_i,
  input  logic [REG_W-1:0]  src_b_i,
  input  logic [DATA_W-1:0] rf_a_i,
  input  logic [DATA_W-1:0] rf_b_i,
  input  logic [REG_W-1:0]  mem_dst_i,
  input  logic [DATA_W-1:0] mem_val_i,
  input  logic [REG_W-1:0]  wb_dst_i,
  input  logic [DATA_W-1:0] wb_val_i,
  input  logic [OP_W-1:0]   ex_op_i,
  input  logic [REG_W-1:0]  ex_dst_i,
  output logic [DATA_W-1:0] opnd_a_o,
  output logic [DATA_W-1:0] opnd_b_o,
  output logic              load_use_o,
  output logic              stall_fetch_o,
  output logic              stall_dec_o,
  output logic              bubble_ex_o
);
  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0]  src_vec;
  logic [NUM_SRC-1:0][DATA_W-1:0] rf_vec;
  logic [NUM_SRC-1:0][DATA_W-1:0] opnd_vec;
  dec_fwd_pkg::hz_ctrl_t          ctrl;

  assign src_vec = {src_b_i, src_a_i};
  assign rf_vec  = {rf_b_i, rf_a_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    fwd_operand_mux #(.REG_W(REG_W), .DATA_W(DATA_W)) u_mux (
      .src_i     (src_vec[g]),
      .rf_i      (rf_vec[g]),
      .mem_dst_i (mem_dst_i),
      .mem_val_i (mem_val_i),
      .wb_dst_i  (wb_dst_i),
      .wb_val_i  (wb_val_i),
      .opnd_o    (opnd_vec[g])
    );
  end

  load_use_detect #(
    .REG_W(REG_W), .OP_W(OP_W), .NUM_SRC(NUM_SRC), .LOAD_OP(LOAD_OP)
  ) u_detect (
    .src_i      (src_vec),
    .ex_op_i    (ex_op_i),
    .ex_dst_i   (ex_dst_i),
    .load_use_o (load_use_o),
    .ctrl_o     (ctrl)
  );

  assign opnd_a_o      = opnd_vec[0];
  assign opnd_b_o      = opnd_vec[1];
  assign stall_fetch_o = ctrl.stall_fetch;
  assign stall_dec_o   = ctrl.stall_dec;
  assign bubble_ex_o   = ctrl.bubble_ex;

  always_comb begin
    a_r9_ctrl_agree: assert (stall_fetch_o == load_use_o && stall_dec_o == load_use_o
                             && bubble_ex_o == load_use_o);
    if (src_a_i == src_b_i) a_r5_same_src_same_opnd: assert (opnd_a_o == opnd_b_o
                                                             || rf_a_i != rf_b_i);
  end
endmodule

// File: tb/dec_fwd_interlock_tb.sv
module dec_fwd_interlock_tb_top;
  localparam int REG_W = 4;
  localparam int DATA_W = 64;
  localparam int OP_W = 4;
  localparam logic [3:0] NONE = 4'hF;
  localparam logic [3:0] LOAD = 4'h5;
  localparam logic [3:0] NOP  = 4'h1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [REG_W-1:0]  src_a, src_b, mem_dst, wb_dst, ex_dst;
  logic [DATA_W-1:0] rf_a, rf_b, mem_val, wb_val;
  logic [OP_W-1:0]   ex_op;
  logic [DATA_W-1:0] opnd_a, opnd_b;
  logic load_use, st_f, st_d, bub_e;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  dec_fwd_interlock dut_i (
    .src_a_i(src_a), .src_b_i(src_b), .rf_a_i(rf_a), .rf_b_i(rf_b),
    .mem_dst_i(mem_dst), .mem_val_i(mem_val), .wb_dst_i(wb_dst), .wb_val_i(wb_val),
    .ex_op_i(ex_op), .ex_dst_i(ex_dst), .opnd_a_o(opnd_a), .opnd_b_o(opnd_b),
    .load_use_o(load_use), .stall_fetch_o(st_f), .stall_dec_o(st_d), .bubble_ex_o(bub_e)
  );

  function automatic logic [DATA_W-1:0] exp_opnd(logic [3:0] s, logic [DATA_W-1:0] rf);
    if (s == NONE) return '0;
    if (mem_dst != NONE && s == mem_dst) return mem_val;
    if (wb_dst != NONE && s == wb_dst) return wb_val;
    return rf;
  endfunction

  function automatic string opnd_req(logic [3:0] s);
    if (s == NONE) return "R1";
    if (mem_dst != NONE && s == mem_dst) return "R2";
    if (wb_dst != NONE && s == wb_dst) return "R3";
    return "R4";
  endfunction

  function automatic logic exp_lu();
    return ex_op == LOAD && ex_dst != NONE && (src_a == ex_dst || src_b == ex_dst);
  endfunction

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic lu;
    lu = exp_lu();
    chk({tag, " opndA ", opnd_req(src_a), " R5"}, opnd_a, exp_opnd(src_a, rf_a));
    chk({tag, " opndB ", opnd_req(src_b), " R5"}, opnd_b, exp_opnd(src_b, rf_b));
    chk({tag, " R7 R8 R6 load_use"}, 64'(load_use), 64'(lu));
    chk({tag, " R9 ctrl"}, 64'({st_f, st_d, bub_e}), 64'({lu, lu, lu}));
  endtask

  task automatic apply(logic [3:0] sa, logic [3:0] sb, logic [3:0] md, logic [3:0] wd,
                       logic [3:0] eo, logic [3:0] ed);
    @(posedge clk);
    src_a = sa; src_b = sb; mem_dst = md; wb_dst = wd; ex_op = eo; ex_dst = ed;
    @(negedge clk);
  endtask

  function automatic logic [3:0] pick_reg();
    int r = $urandom_range(0, 4);
    return (r == 4) ? NONE : 4'(r);
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    rf_a = 64'h1111_0000_0000_00AA; rf_b = 64'h2222_0000_0000_00BB;
    mem_val = 64'h0000_0000_0000_0200; wb_val = 64'h0000_0000_0000_00FE;
    src_a = NONE; src_b = NONE; mem_dst = NONE; wb_dst = NONE; ex_op = NOP; ex_dst = NONE;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle: R1 zero operands, R9 no controls
    chk("R1 idle opndA", opnd_a, '0);
    chk("R1 idle opndB", opnd_b, '0);
    chk("R9 idle ctrl", 64'({load_use, st_f, st_d, bub_e}), 64'(0));

    // R2 both later stages match, memory wins
    apply(4'd3, 4'd3, 4'd3, 4'd3, NOP, NONE);
    chk("R2 mem over wb", opnd_a, mem_val);
    // R3 writeback only
    apply(4'd2, 4'd0, 4'd1, 4'd2, NOP, NONE);
    chk("R3 wb path", opnd_a, wb_val);
    chk("R4 rf path B", opnd_b, rf_b);
    // R5 different paths at once
    apply(4'd1, 4'd2, 4'd1, 4'd2, NOP, NONE);
    chk("R5 A from mem", opnd_a, mem_val);
    chk("R5 B from wb", opnd_b, wb_val);
    // R6 none destinations never match a none source path nor stall
    apply(4'd0, NONE, NONE, NONE, LOAD, NONE);
    chk("R6 none dst opndA", opnd_a, rf_a);
    chk("R6 none ex dst", 64'(load_use), 64'(0));
    // R8 match on B only still stalls
    apply(NONE, 4'd6, NONE, NONE, LOAD, 4'd6);
    chk("R8 B-only hazard", 64'(load_use), 64'(1));
    // R9 non-load with matching dst does not stall
    apply(4'd6, 4'd6, NONE, NONE, NOP, 4'd6);
    chk("R9 nonload quiet", 64'({st_f, st_d, bub_e}), 64'(0));

    // R10 back-to-back loads: load r0 <- [..]; load r2 <- [r0]
    apply(NONE, 4'd0, NONE, NONE, LOAD, 4'd0);
    chk("R10 cycle1 stall", 64'({load_use, st_f, st_d, bub_e}), 64'hF);
    apply(NONE, 4'd0, 4'd0, NONE, NOP, NONE);
    chk("R10 cycle2 no stall", 64'(load_use), 64'(0));
    chk("R10 cycle2 mem fwd", opnd_b, mem_val);
    // distance three: from writeback
    apply(NONE, 4'd0, NONE, 4'd0, NOP, NONE);
    chk("R10 dist3 wb fwd", opnd_b, wb_val);
    chk("R10 dist3 no stall", 64'(load_use), 64'(0));

    for (int i = 0; i < 2000; i++) begin
      @(posedge clk);
      src_a = pick_reg(); src_b = pick_reg();
      mem_dst = pick_reg(); wb_dst = pick_reg(); ex_dst = pick_reg();
      ex_op = ($urandom_range(0, 1) == 1) ? LOAD : 4'($urandom_range(0, 15));
      rf_a = {$urandom, $urandom}; rf_b = {$urandom, $urandom};
      mem_val = {$urandom, $urandom}; wb_val = {$urandom, $urandom};
      @(negedge clk);
      check_all("rand");
    end
    done = 1;
    finish_run();
  end
endmodule